// File: doc/BRIEF.md
# CAS-before-RAS Refresh Sequencer

This block runs one CAS-before-RAS refresh cycle on a DRAM interface each time a refresh trigger is accepted. A synchronous state machine walks the states IDLE → PRECH (0 to 3 repetitions) → T1 → T2 → RCWAIT (1 to 7 repetitions) → T3 → TI. From TI it goes back to IDLE, or it starts the next cycle at once when a trigger is pending or present. Two wait fields set how many times the repeated states run. The precharge field gives 0 to 3 PRECH states. The RAS-CAS field gives RCWAIT states, and a programmed zero still gives one. Both fields are sampled in the cycle where a refresh is accepted.

The active-low refresh strobe, both CAS lines and the busy flag change only on rising clock edges. The strobe, both CAS lines and busy are active in every state from the first PRECH (or T1) through T3. The eight RAS lines fall together on the falling clock edge in the middle of T2. They rise on the rising edge that leaves T3. This gives a precharge of (1.5 + precharge waits) clocks, a RAS pulse of (1.5 + effective RAS-CAS waits) clocks, and a CAS low time of (3 + both waits) clocks. `done` is high for the single TI cycle. A trigger that arrives during a cycle is held and served right after TI. A cycle in progress is never cut short.

Top module: `cbr_refresh_seq`

## Requirements
- R1: After an accepted trigger the states run in the fixed order PRECH*, T1, T2, RCWAIT+, T3, TI, and a started cycle always reaches TI. The active window therefore lasts A = P + 3 + E clocks, where P is the precharge waits and E is the effective RAS-CAS waits.
- R2: `prech_wait` (2 bits, value P = 0..3) adds P PRECH states. RAS stays high for 2P + 3 half-periods after the strobe falls.
- R3: The effective RAS-CAS wait count is E = max(1, `rascas_wait`), with 3 bits. RAS stays low for 2E + 3 half-periods: from the mid-T2 falling edge to the rising edge that ends T3.
- R4: `ucas_n` and `lcas_n` fall together with the strobe and rise together with RAS, so they are low for 2A half-periods. Both are low whenever RAS is low, and CAS leads the RAS fall by at least one clock.
- R5: `rfsh_strobe_n` is low for exactly the A clocks of the active window and changes only on rising edges.
- R6: All `RAS_LINES` RAS outputs always carry the same value.
- R7: `busy` is high for exactly the A active clocks. `done` is high for the one clock right after them (TI).
- R8: A trigger seen while a cycle is active is held. The next cycle starts on the rising edge that ends TI, so the strobe is high for exactly one clock between the two cycles. Extra triggers during the same cycle add no further cycle.
- R9: The wait fields are sampled only when a cycle is accepted. Changing them during a cycle has no effect on that cycle's timing.
- R10: During reset the strobe, all RAS lines and both CAS lines are high, and `busy` and `done` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; states change on the rising edge, RAS falls on the falling edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| refresh_trig | input | 1 | Refresh trigger, sampled on the rising edge |
| prech_wait | input | RRW_W (2) | Extra precharge wait states |
| rascas_wait | input | RCW_W (3) | RAS-CAS wait states, minimum one |
| rfsh_strobe_n | output | 1 | Active-low refresh-in-progress strobe |
| ras_n | output | RAS_LINES (8) | Active-low RAS lines, driven together |
| ucas_n | output | 1 | Active-low upper CAS |
| lcas_n | output | 1 | Active-low lower CAS |
| busy | output | 1 | High during the active refresh window |
| done | output | 1 | One-clock pulse in the TI state |

## Verification
The assertions assume that `refresh_trig` and the wait fields are steady around each rising edge and settle between edges. The bench meets this by changing its inputs only a little after a clock edge. The assertions also assume that reset is applied from time zero and released away from an edge. Every wait value the bench drives stays inside the field widths. The mid-cycle field change and the second trigger during a busy cycle are both driven after the cycle's start edge, so they hit only the latched-field and pending paths.

// File: rtl/cbr_pkg.sv
package cbr_pkg;
    typedef enum logic [2:0] {
        ST_IDLE   = 3'd0,
        ST_PRECH  = 3'd1,
        ST_T1     = 3'd2,
        ST_T2     = 3'd3,
        ST_RCWAIT = 3'd4,
        ST_T3     = 3'd5,
        ST_TI     = 3'd6
    } cbr_state_e;
endpackage

// File: rtl/cbr_wait_counter.sv
module cbr_wait_counter #(
    parameter int W = 3
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         load,
    input  logic [W-1:0] load_val,
    input  logic         dec,
    output logic         zero
);
    logic [W-1:0] cnt_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            cnt_q <= '0;
        else if (load)
            cnt_q <= load_val;
        else if (dec && cnt_q != '0)
            cnt_q <= cnt_q - W'(1);
    end

    assign zero = (cnt_q == '0);

    // a load never arrives while the count is still running down
    AST_LOAD_WHEN_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        (load && dec) |-> zero);                                      // R1
endmodule

// File: rtl/cbr_ras_stage.sv
module cbr_ras_stage #(
    parameter int LINES = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             arm,
    output logic [LINES-1:0] ras_n
);
    logic low_q;

    // falling-edge register gives the half-period RAS fall
    always_ff @(negedge clk or negedge rst_n) begin
        if (!rst_n)
            low_q <= 1'b0;
        else
            low_q <= arm;
    end

    for (genvar g = 0; g < LINES; g++) begin : g_line
        assign ras_n[g] = ~(low_q & arm);
    end

    AST_RAS_LINES_MATCH: assert property (@(posedge clk) disable iff (!rst_n)
        ($countones(ras_n) == 0) || ($countones(ras_n) == LINES));    // R6
endmodule

// File: rtl/cbr_refresh_seq.sv
module cbr_refresh_seq #(
    parameter int RRW_W     = 2,
    parameter int RCW_W     = 3,
    parameter int RAS_LINES = 8
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 refresh_trig,
    input  logic [RRW_W-1:0]     prech_wait,
    input  logic [RCW_W-1:0]     rascas_wait,
    output logic                 rfsh_strobe_n,
    output logic [RAS_LINES-1:0] ras_n,
    output logic                 ucas_n,
    output logic                 lcas_n,
    output logic                 busy,
    output logic                 done
);
    import cbr_pkg::*;

    localparam int CW = (RCW_W > RRW_W) ? RCW_W : RRW_W;

    cbr_state_e       state_q, state_d;
    logic             pending_q;
    logic [RCW_W-1:0] rcw_q;
    logic             start_go;
    logic             cnt_load, cnt_dec, cnt_zero;
    logic [CW-1:0]    cnt_val;
    logic             ras_arm;
    logic             active;

    // start acceptance: from IDLE, or straight out of TI
    assign start_go = (state_q == ST_IDLE || state_q == ST_TI)
                      && (refresh_trig || pending_q);

    // next-state logic
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE, ST_TI: begin
                if (start_go)
                    state_d = (prech_wait != '0) ? ST_PRECH : ST_T1;
                else
                    state_d = ST_IDLE;
            end
            ST_PRECH:  state_d = cnt_zero ? ST_T1 : ST_PRECH;
            ST_T1:     state_d = ST_T2;
            ST_T2:     state_d = ST_RCWAIT;
            ST_RCWAIT: state_d = cnt_zero ? ST_T3 : ST_RCWAIT;
            ST_T3:     state_d = ST_TI;
            default:   state_d = ST_IDLE;
        endcase
    end

    // state register and cycle context
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q   <= ST_IDLE;
            pending_q <= 1'b0;
            rcw_q     <= '0;
        end else begin
            state_q <= state_d;
            if (start_go) begin
                pending_q <= 1'b0;
                rcw_q     <= rascas_wait;
            end else if (refresh_trig && state_q != ST_IDLE) begin
                pending_q <= 1'b1;
            end
        end
    end

    // wait counter: loaded on start (precharge) and in T2 (RAS-CAS)
    always_comb begin
        cnt_load = 1'b0;
        cnt_val  = '0;
        if (start_go) begin
            cnt_load = 1'b1;
            cnt_val  = (prech_wait != '0) ? CW'(prech_wait) - CW'(1) : '0;
        end else if (state_q == ST_T2) begin
            cnt_load = 1'b1;
            cnt_val  = (rcw_q != '0) ? CW'(rcw_q) - CW'(1) : '0;
        end
    end

    assign cnt_dec = (state_q == ST_PRECH) || (state_q == ST_RCWAIT);

    cbr_wait_counter #(.W(CW)) u_wait (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (cnt_load),
        .load_val (cnt_val),
        .dec      (cnt_dec),
        .zero     (cnt_zero)
    );

    // output decode from the state register
    always_comb begin
        active  = 1'b0;
        ras_arm = 1'b0;
        done    = 1'b0;
        unique case (state_q)
            ST_PRECH, ST_T1:        active = 1'b1;
            ST_T2, ST_RCWAIT, ST_T3: begin
                active  = 1'b1;
                ras_arm = 1'b1;
            end
            ST_TI:                  done = 1'b1;
            default: ;
        endcase
    end

    assign rfsh_strobe_n = ~active;
    assign ucas_n        = ~active;
    assign lcas_n        = ~active;
    assign busy          = active;

    cbr_ras_stage #(.LINES(RAS_LINES)) u_ras (
        .clk   (clk),
        .rst_n (rst_n),
        .arm   (ras_arm),
        .ras_n (ras_n)
    );

    AST_NO_ABORT: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q inside {ST_PRECH, ST_T1, ST_T2, ST_RCWAIT})
        |=> (state_q inside {ST_PRECH, ST_T1, ST_T2, ST_RCWAIT, ST_T3})); // R1
    AST_PRE_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_PRECH) |=> (state_q inside {ST_PRECH, ST_T1}));    // R2
    AST_RCW_MIN_ONE: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_T2) |=> (state_q == ST_RCWAIT));                   // R3
    AST_CAS_COVERS_RAS: assert property (@(posedge clk) disable iff (!rst_n)
        !(&ras_n) |-> (!ucas_n && !lcas_n));                              // R4
    AST_DONE_AFTER_T3: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> ($past(state_q) == ST_T3));                              // R7
    AST_PENDING_SERVED: assert property (@(posedge clk) disable iff (!rst_n)
        (pending_q && state_q == ST_TI) |=> !rfsh_strobe_n);              // R8
endmodule

// File: tb/cbr_refresh_seq_bench.sv
module cbr_refresh_seq_bench;
    localparam int NS = 64;
    localparam int NV = 8;
    // vector: {precharge waits[1:0], RAS-CAS field[2:0], expected effective waits[2:0]}
    localparam logic [7:0] VEC [NV] = '{
        {2'd0, 3'd0, 3'd1}, {2'd0, 3'd1, 3'd1}, {2'd1, 3'd2, 3'd2},
        {2'd2, 3'd0, 3'd1}, {2'd3, 3'd7, 3'd7}, {2'd1, 3'd5, 3'd5},
        {2'd3, 3'd1, 3'd1}, {2'd2, 3'd3, 3'd3}
    };

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       trig = 1'b0;
    logic [1:0] pw = '0;
    logic [2:0] rw = '0;
    logic       strb_n, ucas, lcas, busy, done;
    logic [7:0] ras;

    int checks = 0, fails = 0;
    bit finished = 0;
    logic s_strb [NS];

    // counters filled by capture
    int strb_first, strb_cnt, ras_first, ras_cnt, cas_first, cas_cnt;
    int busy_cnt, done_first, done_cnt, ras_mixed, cas_split;

    always #5 clk = ~clk;

    cbr_refresh_seq u_cbr_refresh_seq (
        .clk(clk), .rst_n(rst_n), .refresh_trig(trig),
        .prech_wait(pw), .rascas_wait(rw),
        .rfsh_strobe_n(strb_n), .ras_n(ras), .ucas_n(ucas), .lcas_n(lcas),
        .busy(busy), .done(done)
    );

    task automatic chk(input string req, input string what, input int act, input int exp);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    task automatic finish_run();
        if (!finished) begin
            finished = 1;
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    endtask

    // one trigger, then NS half-period samples taken 2 ns after each edge
    task automatic capture(input int p, input int r, input bit chg, input bit pend);
        @(negedge clk);
        pw = 2'(p); rw = 3'(r); trig = 1'b1;
        strb_first = -1; strb_cnt = 0; ras_first = -1; ras_cnt = 0;
        cas_first = -1; cas_cnt = 0; busy_cnt = 0; done_first = -1; done_cnt = 0;
        ras_mixed = 0; cas_split = 0;
        for (int i = 0; i < NS; i++) begin
            @(posedge clk or negedge clk);
            #2;
            s_strb[i] = strb_n;
            if (!strb_n) begin strb_cnt++; if (strb_first < 0) strb_first = i; end
            if (ras == 8'h00) begin ras_cnt++; if (ras_first < 0) ras_first = i; end
            else if (ras != 8'hFF) ras_mixed++;
            if (ucas != lcas) cas_split++;
            if (!ucas) begin cas_cnt++; if (cas_first < 0) cas_first = i; end
            if (busy) busy_cnt++;
            if (done) begin done_cnt++; if (done_first < 0) done_first = i; end
            if (i == 0) begin
                trig = 1'b0;
                if (chg) begin pw = 2'd3; rw = 3'd7; end
            end
            if (pend && i == 2) trig = 1'b1;
            if (pend && i == 4) trig = 1'b0;
        end
    endtask

    initial begin
        #2_000_000;
        if (!finished) begin
            checks++; fails++;
            $display("FAIL watchdog actual=timeout expected=completion");
            finish_run();
        end
    end

    initial begin
        // R10: reset state
        #12;
        chk("R10", "strobe in reset", int'(strb_n), 1);
        chk("R10", "ras in reset", int'(ras), 255);
        chk("R10", "cas in reset", int'(ucas & lcas), 1);
        chk("R10", "busy/done in reset", int'(busy | done), 0);
        @(negedge clk); #1 rst_n = 1'b1;
        repeat (2) @(negedge clk);

        // table walk: R1 R2 R3 R4 R5 R6 R7
        for (int v = 0; v < NV; v++) begin
            int p, r, e, a;
            p = int'(VEC[v][7:6]); r = int'(VEC[v][5:3]); e = int'(VEC[v][2:0]);
            a = p + 3 + e;
            capture(p, r, 1'b0, 1'b0);
            chk("R5", "strobe first low", strb_first, 0);
            chk("R5", "strobe low halves", strb_cnt, 2 * a);
            chk("R2", "ras fall half", ras_first, 2 * p + 3);
            chk("R3", "ras low halves", ras_cnt, 2 * e + 3);
            chk("R4", "cas first low", cas_first, 0);
            chk("R4", "cas low halves", cas_cnt, 2 * a);
            chk("R4", "ucas/lcas split", cas_split, 0);
            chk("R6", "ras lines mixed", ras_mixed, 0);
            chk("R7", "busy halves", busy_cnt, 2 * a);
            chk("R7", "done halves", done_cnt, 2);
            chk("R1", "done position", done_first, 2 * a);
            repeat (3) @(negedge clk);
        end

        // R9: fields changed right after start do not alter the cycle (P=0, E=1)
        capture(0, 1, 1'b1, 1'b0);
        chk("R9", "strobe low halves", strb_cnt, 8);
        chk("R9", "ras fall half", ras_first, 3);
        chk("R9", "ras low halves", ras_cnt, 5);
        repeat (2) @(negedge clk);

        // R8: trigger during a busy cycle (P=0, E=1, A=4)
        capture(0, 1, 1'b0, 1'b1);
        chk("R8", "strobe high in TI a", int'(s_strb[8]), 1);
        chk("R8", "strobe high in TI b", int'(s_strb[9]), 1);
        chk("R8", "second cycle start", int'(s_strb[10]), 0);
        chk("R8", "two cycles only", strb_cnt, 16);
        chk("R8", "two done pulses", done_cnt, 4);
        repeat (4) @(negedge clk);
        chk("R8", "idle after pending", int'(busy), 0);

        finish_run();
    end
endmodule